// File: doc/BRIEF.md
# Four-Channel Pulse Width Modulator with Step Prescalers

This block generates four independent pulse-width-modulated outputs. A small 32-bit register bus, with a write strobe, a read strobe, a byte address and write and read data, programs the block. One shared control register holds an enable bit and a 2-bit step-clock select for every channel. Each channel also has a configuration word that gives its period (the timebase, in steps) and its high time (the duty, in steps).

Each channel derives its step clock from the block clock through two cascaded prescale stages, divide-by-8 and divide-by-64. The 2-bit select picks a step of 1, 8, 64 or 512 clocks. A per-channel counter runs over the timebase one step at a time. The output is high while the count is below the duty.

New timebase and duty values take effect only at a period boundary, so a running waveform never produces a cut-short cycle. Clearing an enable bit stops that channel at once and returns it to its start state.

Top module: `pwmq_top`

## Requirements
- R1: The four channels run at the same time, each with its own timebase, duty and step select, and channel n drives bit n of `pwmOut` independently of the others.
- R2: Register map (byte addresses): the control register is at 0x00, with enable of channel n at bit n and the step select of channel n at bits [2n+5:2n+4]. Bits [31:12] of the control register read 0. The configuration of channel n is at 0x04+4n, with the timebase in bits [15:0] and the duty in bits [31:16]. A read strobe at a clock edge loads the addressed value into `busRdata`, where it stays until the next read.
- R3: While enabled, a channel's counter steps 0, 1, …, timebase-1 and then wraps to 0. The output is high exactly while count < duty. Counting starts from 0 in the cycle right after the write that sets the enable bit.
- R4: Step select code 0, 1, 2 and 3 makes each count step last 1, 8, 64 and 512 clock cycles.
- R5: A duty of 0 gives a constant low output. A duty equal to or greater than the timebase gives a constant high output.
- R6: In the cycle after a control write that clears a channel's enable bit, its output is low. Setting the bit again restarts the channel from count 0 with a fresh prescaler.
- R7: A configuration write to a running channel does not change its waveform until the current period ends. The new values apply from the first step of the next period.
- R8: Reset clears every register to zero and holds all outputs low.
- R9: A write to an address that is not one of the five registers changes no register, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the prescalers count its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| pwmOut | output | 4 | Channel outputs, bit n for channel n |

## Verification
The assertions check these properties on every cycle:
- a running counter stays below its timebase;
- the counter moves only on a step tick;
- the active timebase and duty hold between period boundaries;
- a full duty keeps the output high;
- a disabled channel sits at count 0;
- a write to an unmapped address changes no register.

Only the bench scenarios can show the rest: that the waveform has the right step length for each select code, that a pending configuration appears in the cycle right after the old period ends, and that four channels with different settings, started by one control write, match their expected waveforms cycle by cycle. Constrained-random settings compare every output cycle against a bench model.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int NUM_CH        = 4;
  localparam int BUS_W         = 32;
  localparam int FIELD_W       = 16;
  localparam int DIV_W         = 2;
  localparam int PRE_A_LOG     = 3;   // first stage: divide by 8
  localparam int PRE_B_LOG     = 6;   // second stage: divide by 64
  localparam int CTRL_DIV_BASE = 4;
  localparam int CTRL_W        = CTRL_DIV_BASE + DIV_W * NUM_CH;

  // Control-to-datapath bundle, driven by the register block
  typedef struct packed {
    logic [NUM_CH-1:0]              chanEn;
    logic [NUM_CH-1:0][DIV_W-1:0]   divSel;
    logic [NUM_CH-1:0][FIELD_W-1:0] tbShadow;
    logic [NUM_CH-1:0][FIELD_W-1:0] dutyShadow;
  } pwmqCtl_t;
endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
  import pwmq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output pwmqCtl_t          ctl
);
  localparam int IDX_W = ADDR_W - 2;

  logic [CTRL_W-1:0]             ctrlReg;
  logic [NUM_CH-1:0][BUS_W-1:0]  cfgReg;
  logic [IDX_W-1:0]              wordIdx;
  logic                          aligned;
  logic                          ctrlHit;
  logic [NUM_CH-1:0]             cfgHit;
  logic [BUS_W-1:0]              rdNext;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign ctrlHit = aligned && (wordIdx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrlReg <= '0;
    else if (busWe && ctrlHit) ctrlReg <= busWdata[CTRL_W-1:0];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_cfg
    assign cfgHit[n] = aligned && (wordIdx == IDX_W'(n + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) cfgReg[n] <= '0;
      else if (busWe && cfgHit[n]) cfgReg[n] <= busWdata;
    end

    assign ctl.divSel[n]     = ctrlReg[CTRL_DIV_BASE + DIV_W*n +: DIV_W];
    assign ctl.tbShadow[n]   = cfgReg[n][FIELD_W-1:0];
    assign ctl.dutyShadow[n] = cfgReg[n][2*FIELD_W-1:FIELD_W];
  end

  assign ctl.chanEn = ctrlReg[NUM_CH-1:0];

  always_comb begin
    rdNext = '0;
    if (ctrlHit) rdNext[CTRL_W-1:0] = ctrlReg;
    for (int n = 0; n < NUM_CH; n++) begin
      if (cfgHit[n]) rdNext = cfgReg[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busRdata <= '0;
    else if (busRe) busRdata <= rdNext;
  end

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && !ctrlHit && !(|cfgHit)) |=> ($stable(ctrlReg) && $stable(cfgReg))); // R9
endmodule

// File: rtl/pwmq_chan.sv
module pwmq_chan
  import pwmq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [DIV_W-1:0]   divSel,
  input  logic [FIELD_W-1:0] tbNew,
  input  logic [FIELD_W-1:0] dutyNew,
  output logic               pwmOut
);
  logic [PRE_A_LOG-1:0] preA;
  logic [PRE_B_LOG-1:0] preB;
  logic [FIELD_W-1:0]   cnt;
  logic [FIELD_W-1:0]   tbAct;
  logic [FIELD_W-1:0]   dutyAct;
  logic                 aWrap, bWrap, aAdvance, bAdvance, tick, periodEnd;
  logic [FIELD_W:0]     cntNext;

  assign aWrap = &preA;
  assign bWrap = &preB;

  // Select codes: 0 -> /1, 1 -> /8, 2 -> /64, 3 -> both stages cascaded (/512)
  always_comb begin
    unique case (divSel)
      2'd0: begin tick = 1'b1;          aAdvance = 1'b0; bAdvance = 1'b0;  end
      2'd1: begin tick = aWrap;         aAdvance = 1'b1; bAdvance = 1'b0;  end
      2'd2: begin tick = bWrap;         aAdvance = 1'b0; bAdvance = 1'b1;  end
      default: begin tick = aWrap && bWrap; aAdvance = 1'b1; bAdvance = aWrap; end
    endcase
  end

  assign cntNext   = {1'b0, cnt} + (FIELD_W+1)'(1);
  assign periodEnd = (cntNext >= {1'b0, tbAct});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preA    <= '0;
      preB    <= '0;
      cnt     <= '0;
      tbAct   <= '0;
      dutyAct <= '0;
    end else if (!en) begin
      preA    <= '0;
      preB    <= '0;
      cnt     <= '0;
      tbAct   <= tbNew;
      dutyAct <= dutyNew;
    end else begin
      if (aAdvance) preA <= preA + PRE_A_LOG'(1);
      if (bAdvance) preB <= preB + PRE_B_LOG'(1);
      if (tick) begin
        if (periodEnd) begin
          cnt     <= '0;
          tbAct   <= tbNew;
          dutyAct <= dutyNew;
        end else begin
          cnt <= cntNext[FIELD_W-1:0];
        end
      end
    end
  end

  assign pwmOut = en && (cnt < dutyAct);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tbAct != '0) |-> (cnt < tbAct)); // R3
  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt)); // R4
  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tbAct != '0 && dutyAct >= tbAct) |-> pwmOut); // R5
  AST_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && preA == '0 && preB == '0)); // R6
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(tick && periodEnd)) |=> ($stable(tbAct) && $stable(dutyAct))); // R7
endmodule

// File: rtl/pwmq_datapath.sv
module pwmq_datapath
  import pwmq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pwmqCtl_t          ctl,
  output logic [NUM_CH-1:0] pwmOut
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    pwmq_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctl.chanEn[n]),
      .divSel  (ctl.divSel[n]),
      .tbNew   (ctl.tbShadow[n]),
      .dutyNew (ctl.dutyShadow[n]),
      .pwmOut  (pwmOut[n])
    );
  end

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> (pwmOut == '0)); // R8
endmodule

// File: rtl/pwmq_top.sv
module pwmq_top
  import pwmq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic [NUM_CH-1:0] pwmOut
);
  pwmqCtl_t ctl;

  pwmq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .busWe    (busWe),
    .busRe    (busRe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .ctl      (ctl)
  );

  pwmq_datapath u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .pwmOut (pwmOut)
  );
endmodule

// File: tb/pwmq_top_tb.sv
module pwmq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  pwmOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int expTb[4];
  int expDuty[4];
  int expCode[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmq_top u_dut (
    .clk(clk), .rst_n(rst_n), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  function automatic int divFactor(input int code);
    return 1 << (3 * code);
  endfunction

  function automatic bit expBit(input int t, input int tb, input int duty, input int code);
    if (tb == 0) return 1'b0;
    return ((t / divFactor(code)) % tb) < duty;
  endfunction

  function automatic logic [31:0] ctrlWord(input logic [3:0] en);
    logic [31:0] w = {28'd0, en};
    for (int n = 0; n < 4; n++) w[4 + 2*n +: 2] = expCode[n][1:0];
    return w;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busRe = 1'b1; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busRe = 1'b0;
    d = busRdata;
  endtask

  task automatic loadCfg(input int n);
    busWrite(8'(4 + 4*n), {16'(expDuty[n]), 16'(expTb[n])});
  endtask

  // Samples len cycles starting at t=0 (first cycle after the enable edge)
  task automatic sampleRun(input int len, input logic [3:0] mask, input string req);
    int bad[4];
    int firstT[4];
    for (int n = 0; n < 4; n++) begin bad[n] = 0; firstT[n] = -1; end
    for (int t = 0; t < len; t++) begin
      for (int n = 0; n < 4; n++) begin
        if (mask[n] && pwmOut[n] !== expBit(t, expTb[n], expDuty[n], expCode[n])) begin
          if (bad[n] == 0) firstT[n] = t;
          bad[n]++;
        end
      end
      @(negedge clk);
    end
    for (int n = 0; n < 4; n++) begin
      if (mask[n]) begin
        checks++;
        if (bad[n] != 0) begin
          errors++;
          $display("FAIL %s ch%0d tb=%0d duty=%0d code=%0d first mismatch t=%0d actual=%b expected=%b",
                   req, n, expTb[n], expDuty[n], expCode[n], firstT[n],
                   !expBit(firstT[n], expTb[n], expDuty[n], expCode[n]),
                   expBit(firstT[n], expTb[n], expDuty[n], expCode[n]));
        end
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] shadowVal[5];
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4; n++) begin expTb[n] = 0; expDuty[n] = 0; expCode[n] = 0; end
    repeat (3) @(negedge clk);

    // R8: reset state
    check("R8", "pwmOut in reset", {28'd0, pwmOut}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      busRead(8'(4*i), rd);
      check("R8", $sformatf("reg %0d after reset", i), rd, 32'd0);
    end
    check("R8", "pwmOut after reset", {28'd0, pwmOut}, 32'd0);

    // R2: random readback of all mapped registers
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 5; i++) begin
        shadowVal[i] = $urandom;
        busWrite(8'(4*i), shadowVal[i]);
      end
      for (int i = 0; i < 5; i++) begin
        busRead(8'(4*i), rd);
        check("R2", $sformatf("readback reg %0d", i), rd,
              (i == 0) ? (shadowVal[i] & 32'h0000_0FFF) : shadowVal[i]);
      end
    end

    // R9: unmapped write and read
    busWrite(8'h14, 32'hFFFF_FFFF);
    busWrite(8'h02, 32'hFFFF_FFFF);
    busRead(8'h14, rd);
    check("R9", "unmapped read", rd, 32'd0);
    busRead(8'h00, rd);
    check("R9", "ctrl after unmapped write", rd, shadowVal[0] & 32'h0000_0FFF);
    busRead(8'h10, rd);
    check("R9", "cfg3 after unmapped write", rd, shadowVal[4]);

    // R5: duty extremes
    busWrite(8'h00, 32'd0);
    expTb = '{5, 5, 5, 4}; expDuty = '{0, 5, 9, 1}; expCode = '{0, 0, 0, 0};
    for (int n = 0; n < 4; n++) loadCfg(n);
    busWrite(8'h00, ctrlWord(4'hF));
    sampleRun(20, 4'hF, "R5");

    // R4: each step select code on its own channel
    busWrite(8'h00, 32'd0);
    expTb = '{3, 3, 3, 2}; expDuty = '{1, 1, 2, 1}; expCode = '{0, 1, 2, 3};
    for (int n = 0; n < 4; n++) loadCfg(n);
    busWrite(8'h00, ctrlWord(4'hF));
    sampleRun(2 * 2 * 512, 4'hF, "R4");

    // R6: disable forces low, re-enable restarts from zero
    busWrite(8'h00, 32'd0);
    expTb = '{1, 1, 6, 1}; expDuty = '{0, 0, 5, 0}; expCode = '{0, 0, 0, 0};
    loadCfg(2);
    busWrite(8'h00, ctrlWord(4'b0100));
    repeat (3) @(negedge clk);
    busWrite(8'h00, ctrlWord(4'b0000));
    check("R6", "ch2 low after disable", {31'd0, pwmOut[2]}, 32'd0);
    @(negedge clk);
    busWrite(8'h00, ctrlWord(4'b0100));
    sampleRun(18, 4'b0100, "R6");

    // R7: configuration change takes effect at the period end
    busWrite(8'h00, 32'd0);
    expTb[0] = 10; expDuty[0] = 2; expCode[0] = 0;
    loadCfg(0);
    busWrite(8'h00, ctrlWord(4'b0001));
    begin
      int bad = 0;
      bit e;
      for (int t = 0; t < 3; t++) begin
        if (pwmOut[0] !== expBit(t, 10, 2, 0)) bad++;
        @(negedge clk);
      end
      busWrite(8'h04, {16'd7, 16'd10});  // write edge between t=3 and t=4
      for (int t = 4; t < 30; t++) begin
        e = (t < 10) ? expBit(t, 10, 2, 0) : expBit(t - 10, 10, 7, 0);
        if (pwmOut[0] !== e) begin
          if (bad == 0) $display("FAIL R7 t=%0d actual=%b expected=%b", t, pwmOut[0], e);
          bad++;
        end
        @(negedge clk);
      end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL R7 mismatching cycles actual=%0d expected=0", bad);
      end
    end

    // R1 / R3: constrained random settings, all four channels at once
    for (int it = 0; it < 6; it++) begin
      int win = 0;
      busWrite(8'h00, 32'd0);
      for (int n = 0; n < 4; n++) begin
        expCode[n] = int'($urandom % 4);
        expTb[n] = 1 + int'($urandom % ((expCode[n] == 3) ? 3 : (expCode[n] == 2) ? 10 : 20));
        expDuty[n] = int'($urandom % (expTb[n] + 1));
        if (2 * expTb[n] * divFactor(expCode[n]) > win) win = 2 * expTb[n] * divFactor(expCode[n]);
        loadCfg(n);
      end
      if (win > 4000) win = 4000;
      busWrite(8'h00, ctrlWord(4'hF));
      sampleRun(win, 4'hF, (it % 2 == 0) ? "R1" : "R3");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule